// File: doc/BRIEF.md
# 64-bit Flag-Setting Integer ALU

This block is the integer execution unit for a small 64-bit instruction subset. All operands are signed two's-complement values. It takes an operation code, a destination operand, a source operand and a shift amount. In the same cycle it produces the 64-bit result, a destination-write indication and the overflow, sign and zero flags that the operation would leave behind. A three-bit flag register, laid out as `{OF, SF, ZF}`, captures those next-state flags on a clock edge when the flag write enable is high.

The condition evaluator reads the stored flags. It drives a single taken/not-taken bit for one of six signed condition codes. The set-on-condition operation uses that bit: it replaces only the lowest byte of the destination with 0 or 1. Compare subtracts the source from the destination, updates the flags and writes no destination.

Top module: `alu64_flags`

## Requirements
- R1: Arithmetic codes give these results: negate (`op_i`=0) gives −dst, add (1) gives dst+src, subtract (2) gives dst−src, and multiply (3) gives the low 64 bits of the signed 128-bit product.
- R2: Bitwise codes give these results: not (4) gives ~dst, and (5) gives dst&src, or (6) gives dst|src, xor (7) gives dst^src. Arithmetic right shift (8) and zero-filling left shift (9) move dst by `amt_i[5:0]`; the upper bits of `amt_i` are ignored.
- R3: `of_o` is set on signed overflow of add, subtract and compare. For negate it is set only when dst is the minimum value. For multiply it is set when the 128-bit product differs from the sign-extension of its low 64 bits. Logic ops and right shift clear it. Left shift by exactly 1 sets it to dst[63]^dst[62]; any other nonzero left shift clears it.
- R4: For every flag-producing operation, `sf_o` equals result bit 63 and `zf_o` is set exactly when the result is zero.
- R5: Compare (10) computes dst−src for the flags and holds `wr_dst_o` low. All other defined codes drive `wr_dst_o` high. Unused codes (12–15) drive it low and output dst unchanged.
- R6: `cond_true_o` evaluates `cond_i` against the stored flags as follows: 0 is ZF; 1 is !ZF; 2 is SF≠OF; 3 is SF=OF; 4 is (SF≠OF)|ZF; 5 is (SF=OF)&!ZF. Codes 6 and 7 are always false.
- R7: Set-on-condition (11) outputs dst with bits 7:0 replaced by `{7'b0, cond_true_o}`; bits 63:8 are unchanged.
- R8: Set-on-condition, unused codes, and shifts whose effective amount is zero present the stored flags unchanged on `of_o`/`sf_o`/`zf_o`.
- R9: `flags_o` (bit 2 OF, bit 1 SF, bit 0 ZF) clears on synchronous reset. It loads `{of_o,sf_o,zf_o}` on a rising edge with `flag_we_i` high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| cond_i | input | 3 | Condition code to evaluate |
| dst_i | input | 64 | Destination operand |
| src_i | input | 64 | Source operand |
| amt_i | input | 8 | Shift amount (low 6 bits used) |
| flag_we_i | input | 1 | Flag register write enable |
| result_o | output | 64 | Operation result |
| wr_dst_o | output | 1 | Result is to be written to the destination |
| of_o | output | 1 | Next overflow flag |
| sf_o | output | 1 | Next sign flag |
| zf_o | output | 1 | Next zero flag |
| flags_o | output | 3 | Stored flags {OF, SF, ZF} |
| cond_true_o | output | 1 | Selected condition holds on stored flags |

## Verification
The bench targets the overflow boundaries where a careless design goes wrong:
- Adding one to the maximum positive value must set OF.
- Subtracting one from the minimum value must set OF.
- Negating the minimum value must set OF.
- A product of 2^32 by 2^32 has a low half of zero but must still flag overflow; an overflow check that looks only at the low half misses it.

A shift amount of 64 must act as a zero shift and keep the stored flags; a design that uses all eight amount bits clears the result or rewrites the flags instead. Set-on-condition is checked against both outcomes over a patterned destination, which catches a design that clears the upper bytes. Compare is checked for a dropped write indication and for operands subtracted in the wrong order, which flips SF.

// File: rtl/alu64_pkg.sv
package alu64_pkg;
  localparam logic [3:0] OP_NEG  = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_MUL  = 4'd3;
  localparam logic [3:0] OP_NOT  = 4'd4;
  localparam logic [3:0] OP_AND  = 4'd5;
  localparam logic [3:0] OP_OR   = 4'd6;
  localparam logic [3:0] OP_XOR  = 4'd7;
  localparam logic [3:0] OP_SAR  = 4'd8;
  localparam logic [3:0] OP_SHL  = 4'd9;
  localparam logic [3:0] OP_CMP  = 4'd10;
  localparam logic [3:0] OP_SETC = 4'd11;

  localparam logic [2:0] CC_EQ = 3'd0;
  localparam logic [2:0] CC_NE = 3'd1;
  localparam logic [2:0] CC_LT = 3'd2;
  localparam logic [2:0] CC_GE = 3'd3;
  localparam logic [2:0] CC_LE = 3'd4;
  localparam logic [2:0] CC_GT = 3'd5;

  localparam int FLG_OF = 2;
  localparam int FLG_SF = 1;
  localparam int FLG_ZF = 0;
endpackage

// File: rtl/alu64_arith.sv
module alu64_arith
  import alu64_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam logic [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]   sum, diff, neg;
  logic [2*W-1:0] prod;

  always_comb begin
    sum  = a + b;
    diff = a - b;
    neg  = ~a + 1'b1;
    prod = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
    res  = a;
    ovf  = 1'b0;
    case (op)
      OP_NEG: begin
        res = neg;
        ovf = (a == MIN_VAL);
      end
      OP_ADD: begin
        res = sum;
        ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
      end
      OP_SUB, OP_CMP: begin
        res = diff;
        ovf = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
      end
      OP_MUL: begin
        res = prod[W-1:0];
        ovf = (prod[2*W-1:W] != {W{prod[W-1]}});
      end
      default: begin
        res = a;
        ovf = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu64_bitops.sv
module alu64_bitops
  import alu64_pkg::*;
#(
  parameter int W   = 64,
  parameter int SHW = $clog2(W)
) (
  input  logic [3:0]     op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   res,
  output logic           ovf
);
  always_comb begin
    res = a;
    ovf = 1'b0;
    case (op)
      OP_NOT: res = ~a;
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_SAR: res = $unsigned($signed(a) >>> amt);
      OP_SHL: begin
        res = a << amt;
        ovf = (amt == SHW'(1)) && (a[W-1] ^ a[W-2]);
      end
      default: res = a;
    endcase
  end
endmodule

// File: rtl/alu64_cond.sv
module alu64_cond
  import alu64_pkg::*;
(
  input  logic [2:0] cc,
  input  logic [2:0] flags,
  output logic       taken
);
  logic lt;

  always_comb begin
    lt = flags[FLG_SF] ^ flags[FLG_OF];
    case (cc)
      CC_EQ:   taken = flags[FLG_ZF];
      CC_NE:   taken = !flags[FLG_ZF];
      CC_LT:   taken = lt;
      CC_GE:   taken = !lt;
      CC_LE:   taken = lt || flags[FLG_ZF];
      CC_GT:   taken = !lt && !flags[FLG_ZF];
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu64_flags.sv
module alu64_flags
  import alu64_pkg::*;
#(
  parameter int W     = 64,
  parameter int AMT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_i,
  input  logic [2:0]       cond_i,
  input  logic [W-1:0]     dst_i,
  input  logic [W-1:0]     src_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             flag_we_i,
  output logic [W-1:0]     result_o,
  output logic             wr_dst_o,
  output logic             of_o,
  output logic             sf_o,
  output logic             zf_o,
  output logic [2:0]       flags_o,
  output logic             cond_true_o
);
  localparam int SHW = $clog2(W);

  logic [SHW-1:0] sh_amt;
  logic [W-1:0]   arith_res, bit_res;
  logic           arith_ovf, bit_ovf;
  logic           is_arith, is_bit, is_shift, keep_flags;
  logic           ovf_sel;
  logic [2:0]     flags_q;

  assign sh_amt = amt_i[SHW-1:0];

  alu64_arith #(.W(W)) u_arith (
    .op (op_i), .a (dst_i), .b (src_i), .res (arith_res), .ovf (arith_ovf)
  );

  alu64_bitops #(.W(W), .SHW(SHW)) u_bitops (
    .op (op_i), .a (dst_i), .b (src_i), .amt (sh_amt),
    .res (bit_res), .ovf (bit_ovf)
  );

  alu64_cond u_cond (
    .cc (cond_i), .flags (flags_q), .taken (cond_true_o)
  );

  always_comb begin
    is_arith = (op_i <= OP_MUL) || (op_i == OP_CMP);
    is_bit   = (op_i >= OP_NOT) && (op_i <= OP_SHL);
    is_shift = (op_i == OP_SAR) || (op_i == OP_SHL);
    keep_flags = !(is_arith || is_bit) || (is_shift && (sh_amt == '0));

    if (is_arith) begin
      result_o = arith_res;
      ovf_sel  = arith_ovf;
    end else if (is_bit) begin
      result_o = bit_res;
      ovf_sel  = bit_ovf;
    end else if (op_i == OP_SETC) begin
      result_o = {dst_i[W-1:8], 7'b0, cond_true_o};
      ovf_sel  = 1'b0;
    end else begin
      result_o = dst_i;
      ovf_sel  = 1'b0;
    end

    wr_dst_o = (is_arith && (op_i != OP_CMP)) || is_bit || (op_i == OP_SETC);

    if (keep_flags) begin
      of_o = flags_q[FLG_OF];
      sf_o = flags_q[FLG_SF];
      zf_o = flags_q[FLG_ZF];
    end else begin
      of_o = ovf_sel;
      sf_o = result_o[W-1];
      zf_o = (result_o == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      flags_q <= 3'b000;
    else if (flag_we_i)
      flags_q <= {of_o, sf_o, zf_o};
  end

  assign flags_o = flags_q;

  // R5: compare never requests a destination write
  a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CMP) |-> !wr_dst_o);

  // R7: set-on-condition leaves bits above the low byte intact
  a_r7_setc_keeps_upper: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SETC) |-> (result_o[W-1:8] == dst_i[W-1:8]) && (result_o[7:1] == 7'b0));

  // R8: an effective zero shift presents the stored flags
  a_r8_shift0_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    ((op_i == OP_SHL || op_i == OP_SAR) && amt_i[SHW-1:0] == '0)
      |-> ({of_o, sf_o, zf_o} == flags_o));

  // R9: without write enable the stored flags hold
  a_r9_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !flag_we_i |=> $stable(flags_o));

  // R4: after a written add, stored SF is the sign of that sum
  a_r4_sign_follows: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && op_i == OP_ADD) |=> (flags_o[FLG_SF] == $past(result_o[W-1])));

  // R6: equality condition tracks stored ZF
  a_r6_eq_tracks_zf: assert property (@(posedge clk) disable iff (rst)
    (cond_i == CC_EQ) |-> (cond_true_o == flags_o[FLG_ZF]));
endmodule

// File: tb/alu64_flags_bench.sv
module alu64_flags_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = '0;
  logic [2:0]  cond_i = '0;
  logic [63:0] dst_i = '0, src_i = '0;
  logic [7:0]  amt_i = '0;
  logic        flag_we_i = 1'b0;
  logic [63:0] result_o;
  logic        wr_dst_o, of_o, sf_o, zf_o, cond_true_o;
  logic [2:0]  flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4ns clk = ~clk;

  alu64_flags u_alu64_flags (
    .clk(clk), .rst(rst), .op_i(op_i), .cond_i(cond_i), .dst_i(dst_i),
    .src_i(src_i), .amt_i(amt_i), .flag_we_i(flag_we_i), .result_o(result_o),
    .wr_dst_o(wr_dst_o), .of_o(of_o), .sf_o(sf_o), .zf_o(zf_o),
    .flags_o(flags_o), .cond_true_o(cond_true_o)
  );

  // {op, dst, src, amt, result, {of,sf,zf}, wr}
  localparam int NV = 21;
  localparam logic [207:0] VEC [NV] = '{
    {4'd1, 64'd5, 64'd7, 8'd0, 64'd12, 3'b000, 1'b1},                                  // R1 R4
    {4'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 8'd0, 64'h8000_0000_0000_0000, 3'b110, 1'b1}, // R3
    {4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'd0, 64'd0, 3'b001, 1'b1},                  // R4
    {4'd2, 64'd3, 64'd5, 8'd0, 64'hFFFF_FFFF_FFFF_FFFE, 3'b010, 1'b1},                  // R1
    {4'd2, 64'h8000_0000_0000_0000, 64'd1, 8'd0, 64'h7FFF_FFFF_FFFF_FFFF, 3'b100, 1'b1}, // R3
    {4'd0, 64'd0, 64'd0, 8'd0, 64'd0, 3'b001, 1'b1},                                    // R1
    {4'd0, 64'h8000_0000_0000_0000, 64'd0, 8'd0, 64'h8000_0000_0000_0000, 3'b110, 1'b1}, // R3
    {4'd0, 64'd5, 64'd0, 8'd0, 64'hFFFF_FFFF_FFFF_FFFB, 3'b010, 1'b1},                  // R1
    {4'd3, 64'd3, 64'hFFFF_FFFF_FFFF_FFFE, 8'd0, 64'hFFFF_FFFF_FFFF_FFFA, 3'b010, 1'b1}, // R1
    {4'd3, 64'h1_0000_0000, 64'h1_0000_0000, 8'd0, 64'd0, 3'b101, 1'b1},                // R3
    {4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd0, 64'd1, 3'b000, 1'b1}, // R1
    {4'd4, 64'd0, 64'd0, 8'd0, 64'hFFFF_FFFF_FFFF_FFFF, 3'b010, 1'b1},                  // R2
    {4'd5, 64'hF0F0, 64'hFF00, 8'd0, 64'hF000, 3'b000, 1'b1},                           // R2
    {4'd6, 64'd0, 64'd0, 8'd0, 64'd0, 3'b001, 1'b1},                                    // R2
    {4'd7, 64'hA5A5, 64'hA5A5, 8'd0, 64'd0, 3'b001, 1'b1},                              // R2
    {4'd8, 64'h8000_0000_0000_0000, 64'd0, 8'h44, 64'hF800_0000_0000_0000, 3'b010, 1'b1}, // R2
    {4'd9, 64'd1, 64'd0, 8'h3F, 64'h8000_0000_0000_0000, 3'b010, 1'b1},                 // R2 R3
    {4'd9, 64'h4000_0000_0000_0000, 64'd0, 8'd1, 64'h8000_0000_0000_0000, 3'b110, 1'b1}, // R3
    {4'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'd2, 8'd0, 64'hFFFF_FFFF_FFFF_FFFE, 3'b110, 1'b1}, // R3
    {4'd10, 64'd3, 64'd5, 8'd0, 64'hFFFF_FFFF_FFFF_FFFE, 3'b010, 1'b0},                 // R5
    {4'd10, 64'd5, 64'd5, 8'd0, 64'd0, 3'b001, 1'b0}                                    // R5
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [63:0] d, input logic [63:0] s,
                       input logic [7:0] a, input logic [2:0] cc, input logic we);
    @(negedge clk);
    op_i = op; dst_i = d; src_i = s; amt_i = a; cond_i = cc; flag_we_i = we;
    #1ns;
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
    flag_we_i = 1'b0;
    #1ns;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8ns * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1ns;
    chk("R9 reset flags", {61'd0, flags_o}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][207:204], VEC[i][203:140], VEC[i][139:76], VEC[i][75:68], 3'd0, 1'b1);
      chk($sformatf("R1/R2 result vec%0d", i), result_o, VEC[i][67:4]);
      chk($sformatf("R3/R4 flags vec%0d", i), {61'd0, of_o, sf_o, zf_o}, {61'd0, VEC[i][3:1]});
      chk($sformatf("R5 write vec%0d", i), {63'd0, wr_dst_o}, {63'd0, VEC[i][0]});
      tick();
      chk($sformatf("R9 stored vec%0d", i), {61'd0, flags_o}, {61'd0, VEC[i][3:1]});
    end

    // stored flags now 001 (zero)
    apply(4'd0, 0, 0, 0, 3'd0, 1'b0);
    chk("R6 eq true", {63'd0, cond_true_o}, 64'd1);
    apply(4'd0, 0, 0, 0, 3'd1, 1'b0);
    chk("R6 ne false", {63'd0, cond_true_o}, 64'd0);

    // R8: shift by 64 acts as zero shift, flags kept even with write enable
    apply(4'd9, 64'd1, 0, 8'h40, 3'd0, 1'b1);
    chk("R2 shift amount 64 ignored upper bit", result_o, 64'd1);
    chk("R8 zero shift keeps flags", {61'd0, of_o, sf_o, zf_o}, 64'b001);
    tick();
    chk("R8 zero shift stored flags", {61'd0, flags_o}, 64'b001);

    // R9: no write enable, flags hold
    apply(4'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 3'd0, 1'b0);
    tick();
    chk("R9 hold without enable", {61'd0, flags_o}, 64'b001);

    // compare 3 vs 5 -> SF=1 OF=0
    apply(4'd10, 64'd3, 64'd5, 0, 3'd0, 1'b1);
    tick();
    chk("R5 cmp stored", {61'd0, flags_o}, 64'b010);
    apply(4'd0, 0, 0, 0, 3'd2, 1'b0);
    chk("R6 lt", {63'd0, cond_true_o}, 64'd1);
    apply(4'd0, 0, 0, 0, 3'd3, 1'b0);
    chk("R6 ge", {63'd0, cond_true_o}, 64'd0);
    apply(4'd0, 0, 0, 0, 3'd4, 1'b0);
    chk("R6 le", {63'd0, cond_true_o}, 64'd1);
    apply(4'd0, 0, 0, 0, 3'd5, 1'b0);
    chk("R6 gt", {63'd0, cond_true_o}, 64'd0);
    apply(4'd0, 0, 0, 0, 3'd7, 1'b0);
    chk("R6 code 7 false", {63'd0, cond_true_o}, 64'd0);

    // R7 set-on-condition
    apply(4'd11, 64'hAAAA_AAAA_AAAA_AAAA, 0, 0, 3'd2, 1'b1);
    chk("R7 setc true", result_o, 64'hAAAA_AAAA_AAAA_AA01);
    chk("R7 setc write", {63'd0, wr_dst_o}, 64'd1);
    chk("R8 setc keeps flags", {61'd0, of_o, sf_o, zf_o}, 64'b010);
    apply(4'd11, 64'hAAAA_AAAA_AAAA_AAAA, 0, 0, 3'd5, 1'b1);
    chk("R7 setc false", result_o, 64'hAAAA_AAAA_AAAA_AA00);
    tick();
    chk("R8 setc stored flags", {61'd0, flags_o}, 64'b010);

    // R5 unused code
    apply(4'd13, 64'h1234, 64'd9, 0, 3'd0, 1'b0);
    chk("R5 unused passes dst", result_o, 64'h1234);
    chk("R5 unused no write", {63'd0, wr_dst_o}, 64'd0);

    // compare with overflow: min - 1 -> OF=1 SF=0, lt holds
    apply(4'd10, 64'h8000_0000_0000_0000, 64'd1, 0, 3'd2, 1'b1);
    tick();
    chk("R3 cmp overflow stored", {61'd0, flags_o}, 64'b100);
    chk("R6 lt via overflow", {63'd0, cond_true_o}, 64'd1);

    // R9 reset clears
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1ns;
    chk("R9 reset clears stored flags", {61'd0, flags_o}, 64'd0);

    finish_run();
  end
endmodule